// File: doc/BRIEF.md
# Processor Supervisor Watchdog with Reset/Interrupt Steering

This block watches a processor for signs of life. Software arms it by writing one 8-bit configuration word. That word holds a timeout multiplier, a resolution code and a steering bit. The block counts a slow time base that arrives as a single enable pulse every 1/16 s. If software does not write the word again before the programmed period runs out, the watchdog fires.

When steering is set, a timeout raises a reset request for a fixed number of time-base ticks. The configuration is forced to zero at the start of that pulse, so the watchdog disarms itself. When steering is clear, a timeout raises an interrupt request instead. That request stays up until software writes the word again or power fails. Every timeout also sets a sticky status flag, which software clears separately. A power failure disarms the watchdog and drops the interrupt request, so boot code has to arm it again.

The coarse resolutions come from the 1/16 s enable through a divide-by-4 prescaler chain. Each write restarts that prescaler as well as the multiplier count.

Top module: `wdog_supervisor`

## Requirements
- R1: The configuration word has the steering bit in bit 7, the multiplier in bits 6..2 and the resolution code in bits 1..0.
- R2: Resolution code 0 means 1 tick per unit, code 1 means 4 ticks, code 2 means 16 ticks and code 3 means 64 ticks, where one tick is 1/16 s.
- R3: A timeout occurs on the tick numbered multiplier × ticks-per-unit, counted from the tick after the last accepted write. The outputs change on the clock edge that samples that tick.
- R4: With a multiplier of zero, no timeout ever occurs, whatever the resolution.
- R5: An accepted write restarts both the prescaler and the multiplier count. A tick in the same cycle as the write is not counted.
- R6: With steering = 1, a timeout raises rst_req_o for exactly RST_TICKS ticks and clears the configuration to zero. Writes are ignored while the pulse lasts, so no further timeout follows.
- R7: With steering = 0, a timeout raises irq_o. It stays high until an accepted write or pwr_fail_i, even if further periods elapse.
- R8: Every timeout sets flag_o. flag_clr_i clears it, and a timeout in the same cycle as a clear leaves it set.
- R9: pwr_fail_i clears the configuration and irq_o, so the watchdog stays disarmed until the next write.
- R10: After reset all outputs are 0 and the configuration is zero, so the watchdog is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at every 1/16 s |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 8 | Configuration word to be written |
| pwr_fail_i | input | 1 | Power failure detected |
| flag_clr_i | input | 1 | Clear the timeout flag |
| rst_req_o | output | 1 | Reset request pulse (steering = 1) |
| irq_o | output | 1 | Interrupt request (steering = 0) |
| flag_o | output | 1 | Sticky timeout flag |

## Verification
Each output is a single register behind the tick that completes the period. The outputs therefore change on the same edge that samples the final tick, and they can be seen one half-cycle later. The bench drives every input on a falling edge and holds it for one cycle. It samples on the next falling edge, so each check reads the result of exactly the stimulus just applied. Near the end of every period, the bench checks that nothing has fired one tick early and that the output rises on exactly the expected tick. It computes that tick count from the multiplier and the ticks-per-unit scale. The reset pulse is checked in the same way on the tick before it should fall and on the tick where it falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W     = 8;
  localparam int MULT_W    = 5;
  localparam int RES_W     = 2;
  localparam int STEP_LOG2 = 2;
  localparam int PRE_W     = ((1 << RES_W) - 1) * STEP_LOG2;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;

  // last prescaler state for a resolution code: 4**code - 1
  function automatic logic [PRE_W-1:0] res_last(input logic [RES_W-1:0] code);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << (int'(code) * STEP_LOG2);
    return PRE_W'(one_hot - (PRE_W+1)'(1));
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [RES_W-1:0] res_i,
  output logic             unit_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_w;
  logic             wrap_w;

  assign last_w = res_last(res_i);
  assign wrap_w = (pre_q == last_w);
  assign unit_o = tick_i & ~restart_i & wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_i)    pre_q <= wrap_w ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_i,
  input  logic              restart_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              timeout_o
);
  logic [MULT_W-1:0] cnt_q;
  logic              armed_w;

  assign armed_w   = (mult_i != '0);
  assign timeout_o = unit_i & armed_w & (cnt_q == mult_i - MULT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (timeout_o)         cnt_q <= '0;
    else if (unit_i && armed_w) cnt_q <= cnt_q + MULT_W'(1);
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int RST_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);
  localparam int PW = $clog2(RST_TICKS + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      active_o <= 1'b0;
    end else if (start_i) begin
      left_q   <= PW'(RST_TICKS);
      active_o <= 1'b1;
    end else if (active_o && tick_i) begin
      left_q <= left_q - PW'(1);
      if (left_q == PW'(1)) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int RST_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             pwr_fail_i,
  input  logic             flag_clr_i,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             flag_o
);
  wd_cfg_t cfg_q;
  logic    wr_ok_w;
  logic    restart_w;
  logic    unit_w;
  logic    timeout_w;
  logic    tmo_rst_w;
  logic    tmo_irq_w;
  logic    pulse_w;

  assign wr_ok_w   = wr_en_i & ~pulse_w;
  assign restart_w = wr_ok_w | pwr_fail_i;
  assign tmo_rst_w = timeout_w & cfg_q.steer;
  assign tmo_irq_w = timeout_w & ~cfg_q.steer;
  assign rst_req_o = pulse_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (pwr_fail_i) cfg_q <= '0;
    else if (wr_ok_w)    cfg_q <= wd_cfg_t'(wr_data_i);
    else if (tmo_rst_w)  cfg_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (restart_w)      irq_o <= 1'b0;
      else if (tmo_irq_w) irq_o <= 1'b1;
      if (timeout_w)       flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end

  wdog_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .restart_i(restart_w),
    .res_i(cfg_q.res), .unit_o(unit_w)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .unit_i(unit_w), .restart_i(restart_w),
    .mult_i(cfg_q.mult), .timeout_o(timeout_w)
  );

  wdog_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(tmo_rst_w),
    .active_o(pulse_w)
  );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              timeout,
  input logic              tmo_rst,
  input logic              tmo_irq,
  input logic [MULT_W-1:0] mult,
  input logic              pwr_fail,
  input logic              rst_req,
  input logic              irq,
  input logic              flag
);
  a_r4_zero_mult_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (mult != '0));
  a_r5_restart_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !timeout);
  a_r6_steer_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmo_rst, tmo_irq}));
  a_r6_pulse_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !irq);
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !restart) |=> irq);
  a_r8_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag);
  a_r9_pwrfail_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !irq);
endmodule

bind wdog_supervisor wdog_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart_w), .timeout(timeout_w),
  .tmo_rst(tmo_rst_w), .tmo_irq(tmo_irq_w), .mult(cfg_q.mult),
  .pwr_fail(pwr_fail_i), .rst_req(rst_req_o), .irq(irq_o), .flag(flag_o)
);

// File: tb/test_wdog_supervisor.sv
`timescale 1ns/1ps
module test_wdog_supervisor;
  localparam int RST_TICKS = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, wr_en_i = 1'b0, pwr_fail_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic rst_req_o, irq_o, flag_o;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_supervisor #(.RST_TICKS(RST_TICKS)) i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .pwr_fail_i(pwr_fail_i), .flag_clr_i(flag_clr_i),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .flag_o(flag_o)
  );

  task automatic chk(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  // R1: steer bit 7, multiplier bits 6..2, resolution bits 1..0
  task automatic wr(bit s, int m, int r);
    @(negedge clk) begin wr_en_i = 1'b1; wr_data_i = {s, 5'(m), 2'(r)}; end
    @(negedge clk) wr_en_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk) flag_clr_i = 1'b1;
    @(negedge clk) flag_clr_i = 1'b0;
  endtask

  task automatic pfail();
    @(negedge clk) pwr_fail_i = 1'b1;
    @(negedge clk) pwr_fail_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rst_req", rst_req_o, 1'b0);
    chk("R10 irq", irq_o, 1'b0);
    chk("R10 flag", flag_o, 1'b0);
    ticks(100);
    chk("R10 disarmed irq", irq_o, 1'b0);
    chk("R10 disarmed flag", flag_o, 1'b0);

    // R2 R3 sweep: interrupt mode, ticks = mult * 4**res
    for (int r = 0; r < 4; r++) begin
      for (int m = 1; m < 32; m++) begin
        int div;
        if (r >= 2 && m > 3) continue;
        div = 1;
        for (int k = 0; k < r; k++) div *= 4;
        wr(1'b0, m, r);
        ticks(m * div - 1);
        chk("R3 early irq", irq_o, 1'b0);
        chk("R2 early flag", flag_o, 1'b0);
        ticks(1);
        chk("R3 irq on time", irq_o, 1'b1);
        chk("R2 flag on time", flag_o, 1'b1);
        chk("R7 no reset in irq mode", rst_req_o, 1'b0);
        wr(1'b0, 0, 0);
        clr_flag();
        chk("R7 write drops irq", irq_o, 1'b0);
        chk("R8 clear flag", flag_o, 1'b0);
      end
    end

    // R4: zero multiplier at every resolution
    for (int r = 0; r < 4; r++) begin
      wr(1'b0, 0, r);
      ticks(130);
      chk("R4 zero mult irq", irq_o, 1'b0);
      chk("R4 zero mult flag", flag_o, 1'b0);
    end
    wr(1'b1, 0, 0);
    ticks(20);
    chk("R4 zero mult reset", rst_req_o, 1'b0);

    // R5: restart of multiplier count and of prescaler
    wr(1'b0, 3, 0);
    ticks(2);
    wr(1'b0, 3, 0);
    ticks(2);
    chk("R5 mult restart", irq_o, 1'b0);
    ticks(1);
    chk("R5 mult restart late", irq_o, 1'b1);
    wr(1'b0, 1, 1);
    ticks(3);
    @(negedge clk) begin tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = {1'b0, 5'd1, 2'd1}; end
    @(negedge clk) begin tick_i = 1'b0; wr_en_i = 1'b0; end
    chk("R5 tick with write ignored", irq_o, 1'b0);
    ticks(3);
    chk("R5 prescaler restart", irq_o, 1'b0);
    ticks(1);
    chk("R5 prescaler restart late", irq_o, 1'b1);

    // R7 hold across periods, R8 repeated flag, R9 power fail
    clr_flag();
    ticks(4);
    chk("R8 flag set again", flag_o, 1'b1);
    ticks(60);
    chk("R7 irq held", irq_o, 1'b1);
    pfail();
    chk("R9 pwr fail drops irq", irq_o, 1'b0);
    clr_flag();
    ticks(30);
    chk("R9 disarmed irq", irq_o, 1'b0);
    chk("R9 disarmed flag", flag_o, 1'b0);

    // R8: timeout and clear in the same cycle
    wr(1'b0, 2, 0);
    ticks(1);
    @(negedge clk) begin tick_i = 1'b1; flag_clr_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; flag_clr_i = 1'b0; end
    chk("R8 set wins over clear", flag_o, 1'b1);
    wr(1'b0, 0, 0);
    clr_flag();

    // R6: reset steering, pulse length, self clear, writes ignored
    wr(1'b1, 2, 0);
    ticks(1);
    chk("R6 early reset", rst_req_o, 1'b0);
    ticks(1);
    chk("R6 reset on time", rst_req_o, 1'b1);
    chk("R6 flag on reset", flag_o, 1'b1);
    chk("R6 no irq in reset mode", irq_o, 1'b0);
    wr(1'b0, 1, 0);
    ticks(RST_TICKS - 1);
    chk("R6 pulse still high", rst_req_o, 1'b1);
    ticks(1);
    chk("R6 pulse ends", rst_req_o, 1'b0);
    clr_flag();
    ticks(40);
    chk("R6 self disarmed reset", rst_req_o, 1'b0);
    chk("R6 ignored write irq", irq_o, 1'b0);
    chk("R6 self disarmed flag", flag_o, 1'b0);

    summary();
  end
endmodule